// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block turns the free-running oscillator clock into a periodic interrupt request. A binary counter chain runs directly on the oscillator clock, not on the bus or system clock. A single rate value sets the period as the product of two fields. The first is a power-of-two tap that selects a divisor from 2^10 up to 2^16. The second is a linear prescale that multiplies that divisor by 1 to 16. Each time the chain reaches its terminal count, a sticky flag is set. The interrupt request is that flag masked by an enable bit.

Software controls the block through three small write ports: one for the rate value, one for the enable bit, and one write-one-to-clear port for the flag. When a freeze configuration bit is set, the chain stops counting for as long as the wait-mode input is asserted. It then resumes from where it stopped. Writing a rate value restarts the chain, so the first period after a write is always complete. A tap value of zero turns the generator off.

Top module: `rti_gen`

## Requirements
- R1: After reset, `flag_o`, `ie_o` and `irq_o` are all 0.
- R2: The rate value holds the tap field T in bits [6:4] and the prescale field P in bits [3:0]. For T from 1 to 7, `flag_o` rises exactly (P+1)·2^(9+T) oscillator clocks after the edge that captures the rate write. It then rises again with the same spacing for every later period.
- R3: With T = 0 the chain does not count and `flag_o` never sets.
- R4: Once set, `flag_o` stays 1 until `flag_we` is pulsed with `flag_wdata` = 1. A flag write with `flag_wdata` = 0 leaves it set.
- R5: `irq_o` is 1 exactly when both `flag_o` and `ie_o` are 1. `ie_o` takes `ie_wdata` on a cycle where `ie_we` is 1.
- R6: While `wait_i` and `wait_freeze_en` are both 1, the chain holds its count. Each frozen clock delays the next flag by one clock.
- R7: While `wait_freeze_en` is 0, `wait_i` has no effect on the period.
- R8: A rate write restarts the chain from zero, discarding any partial period already counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock driving the chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_we | input | 1 | Rate value write strobe |
| rate_wdata | input | 8 | Rate value: tap in [6:4], prescale in [3:0] |
| ie_we | input | 1 | Enable bit write strobe |
| ie_wdata | input | 1 | New value of the enable bit |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | A 1 clears the flag; a 0 does nothing |
| wait_i | input | 1 | Wait-mode indication |
| wait_freeze_en | input | 1 | When 1, wait mode freezes the chain |
| flag_o | output | 1 | Sticky terminal-count flag |
| ie_o | output | 1 | Interrupt enable bit |
| irq_o | output | 1 | Interrupt request |

## Verification
Periods are measured for several tap and prescale combinations (1×2^10, 3×2^11, 2×2^12). Each measurement checks the flag one clock before and at the expected edge. This separates a correct product from an off-by-one or from a prescale applied to the wrong power. A second consecutive period separates a clean wrap from a drift after the first terminal count. Wait-mode runs with and without the freeze bit distinguish a held count from an ignored input. A mid-period rate rewrite distinguishes a restarted chain from one that keeps its partial count. Tap zero, held over a long window, shows that the generator is truly off.

// File: rtl/rti_pkg.sv
package rti_pkg;
    localparam int TAP_W     = 3;
    localparam int PRE_W     = 4;
    localparam int BASE_LOG2 = 10;
    localparam int CHAIN_W   = BASE_LOG2 - 1 + (2 ** TAP_W) - 1;
    localparam int RATE_W    = 1 + TAP_W + PRE_W;

    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic [PRE_W-1:0] pre;
    } rate_t;

    typedef struct packed {
        logic [CHAIN_W-1:0] cnt;
        logic [PRE_W-1:0]   pre;
    } chain_t;

    typedef struct packed {
        logic flag;
        logic ie;
    } ctl_t;
endpackage

// File: rtl/rti_tap_decode.sv
module rti_tap_decode
    import rti_pkg::*;
#(
    parameter int TW = TAP_W,
    parameter int CW = CHAIN_W,
    parameter int BL = BASE_LOG2
) (
    input  logic [TW-1:0] tap_i,
    output logic [CW-1:0] mask_o,
    output logic          on_o
);
    assign on_o = (tap_i != '0);

    // bit i belongs to the wrap mask when it lies below 9+tap
    for (genvar i = 0; i < CW; i++) begin : g_mask
        assign mask_o[i] = on_o && ((int'(tap_i) + BL - 1) > i);
    end
endmodule

// File: rtl/rti_chain.sv
module rti_chain
    import rti_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               run_i,
    input  logic [CHAIN_W-1:0] mask_i,
    input  logic [PRE_W-1:0]   pre_lim_i,
    output logic               tick_o
);
    chain_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        tick_o = 1'b0;
        if (restart_i) begin
            nxt_d = '0;
        end else if (run_i) begin
            if ((cur_q.cnt & mask_i) == mask_i) begin
                nxt_d.cnt = '0;
                if (cur_q.pre == pre_lim_i) begin
                    nxt_d.pre = '0;
                    tick_o    = 1'b1;
                end else begin
                    nxt_d.pre = cur_q.pre + 1'b1;
                end
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(cur_q)); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cur_q == '0)); // R8
    AST_CNT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> ((cur_q.cnt & ~mask_i) == '0)); // R2
endmodule

// File: rtl/rti_flag.sv
module rti_flag
    import rti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    input  logic ie_we_i,
    input  logic ie_wdata_i,
    output logic flag_o,
    output logic ie_o,
    output logic irq_o
);
    ctl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_i)   nxt_d.flag = 1'b0;
        if (tick_i)  nxt_d.flag = 1'b1;
        if (ie_we_i) nxt_d.ie   = ie_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign flag_o = cur_q.flag;
    assign ie_o   = cur_q.ie;
    assign irq_o  = cur_q.flag & cur_q.ie;

    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.flag) |-> $past(tick_i)); // R4
    AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.flag) |-> $past(clr_i)); // R4
endmodule

// File: rtl/rti_gen.sv
module rti_gen
    import rti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              ie_we,
    input  logic              ie_wdata,
    input  logic              flag_we,
    input  logic              flag_wdata,
    input  logic              wait_i,
    input  logic              wait_freeze_en,
    output logic              flag_o,
    output logic              ie_o,
    output logic              irq_o
);
    rate_t              rate_q, rate_d;
    logic [CHAIN_W-1:0] mask;
    logic               on;
    logic               run;
    logic               tick;

    always_comb begin
        rate_d = rate_q;
        if (rate_we) rate_d = rate_t'(rate_wdata[TAP_W+PRE_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_d;
    end

    rti_tap_decode u_dec (
        .tap_i  (rate_q.tap),
        .mask_o (mask),
        .on_o   (on)
    );

    assign run = on && !(wait_i && wait_freeze_en);

    rti_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (rate_we),
        .run_i     (run),
        .mask_i    (mask),
        .pre_lim_i (rate_q.pre),
        .tick_o    (tick)
    );

    rti_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .clr_i      (flag_we && flag_wdata),
        .ie_we_i    (ie_we),
        .ie_wdata_i (ie_wdata),
        .flag_o     (flag_o),
        .ie_o       (ie_o),
        .irq_o      (irq_o)
    );

    AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q.tap == '0) |-> !tick); // R3
endmodule

// File: tb/tb_rti_gen.sv
module tb_rti_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       rate_we = 0;
    logic [7:0] rate_wdata = 0;
    logic       ie_we = 0, ie_wdata = 0;
    logic       flag_we = 0, flag_wdata = 0;
    logic       wait_i = 0, wait_freeze_en = 0;
    logic       flag_o, ie_o, irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rti_gen dut (
        .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
        .ie_we(ie_we), .ie_wdata(ie_wdata), .flag_we(flag_we),
        .flag_wdata(flag_wdata), .wait_i(wait_i), .wait_freeze_en(wait_freeze_en),
        .flag_o(flag_o), .ie_o(ie_o), .irq_o(irq_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_rate(input logic [2:0] t, input logic [3:0] p);
        rate_we = 1; rate_wdata = {1'b0, t, p};
        edges(1);
        rate_we = 0;
    endtask

    task automatic wr_flag(input logic v);
        flag_we = 1; flag_wdata = v;
        edges(1);
        flag_we = 0;
    endtask

    task automatic wr_ie(input logic v);
        ie_we = 1; ie_wdata = v;
        edges(1);
        ie_we = 0;
    endtask

    task automatic t_reset();
        check(flag_o, 0, "R1 flag");
        check(ie_o, 0, "R1 ie");
        check(irq_o, 0, "R1 irq");
    endtask

    task automatic t_period(input logic [2:0] t, input logic [3:0] p);
        int n = (int'(p) + 1) << (9 + int'(t));
        wr_flag(1);
        wr_rate(t, p);
        edges(n - 1);
        check(flag_o, 0, "R2 before first terminal");
        edges(1);
        check(flag_o, 1, "R2 first terminal");
        wr_flag(1);
        check(flag_o, 0, "R4 cleared by one");
        edges(n - 2);
        check(flag_o, 0, "R2 before second terminal");
        edges(1);
        check(flag_o, 1, "R2 second terminal");
    endtask

    task automatic t_sticky_irq();
        wr_ie(0);
        edges(50);
        check(flag_o, 1, "R4 flag holds");
        check(irq_o, 0, "R5 masked");
        wr_flag(0);
        check(flag_o, 1, "R4 write zero ignored");
        wr_ie(1);
        check(ie_o, 1, "R5 ie written");
        check(irq_o, 1, "R5 irq asserted");
        wr_flag(1);
        check(irq_o, 0, "R5 irq drops with flag");
    endtask

    task automatic t_off();
        wr_rate(0, 5);
        wr_flag(1);
        edges(20000);
        check(flag_o, 0, "R3 tap zero no flag");
    endtask

    task automatic t_wait(input logic frz);
        wr_flag(1);
        wait_freeze_en = frz;
        wr_rate(1, 0);
        edges(100);
        wait_i = 1;
        edges(500);
        wait_i = 0;
        if (frz) begin
            edges(923);
            check(flag_o, 0, "R6 frozen delays flag");
            edges(1);
            check(flag_o, 1, "R6 resumes after wait");
        end else begin
            edges(423);
            check(flag_o, 0, "R7 before terminal");
            edges(1);
            check(flag_o, 1, "R7 wait ignored");
        end
        wait_freeze_en = 0;
    endtask

    task automatic t_restart();
        wr_flag(1);
        wr_rate(1, 0);
        edges(600);
        wr_rate(1, 0);
        edges(1023);
        check(flag_o, 0, "R8 partial period discarded");
        edges(1);
        check(flag_o, 1, "R8 full period after rewrite");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        edges(3);
        t_reset();
        rst_n = 1;
        edges(2);
        t_reset();
        t_period(1, 0);
        t_sticky_irq();
        t_period(2, 2);
        t_period(3, 1);
        t_off();
        t_wait(1);
        t_wait(0);
        t_restart();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule